// File: doc/BRIEF.md
# Two-State Intersymbol-Interference Viterbi Decoder

This block recovers a binary data stream from a channel whose memory is one bit. The ideal received value is the sum of the present data bit and the one before it, so it is 0, 1 or 2. Each accepted cycle brings one signed quantized sample. The decoder scores both trellis states with soft costs taken from that sample and keeps the two path metrics renormalised. It records one survivor bit per state for each stage and traces back from the better state. One decoded bit leaves the block for each accepted sample, after a fixed latency counted in accepted samples.

The traceback spans `TB_LEN` trellis state columns, six by default. The first pointer comes from the survivor pair being formed in the current cycle. The remaining `TB_LEN-2` pointers come from a shift register of stored stages, which advances by one stage for every accepted sample. The result is registered, so a decoded bit appears in the cycle after the sample that completes its traceback window.

Top module: `isi_viterbi2`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dec_valid` and `dec_bit` are 0. Both path metrics and every stored survivor bit are cleared.
- R2: `dec_valid` stays low until `TB_LEN` samples have been accepted since reset. From then on it is high for exactly one cycle per accepted sample, in the cycle after that sample's clock edge.
- R3: For an accepted sample s, the cost of a transition is |s - e|. The expected value e is 0 for a 0-to-0 transition, 1 for a 0-to-1 or 1-to-0 transition, and 2 for a 1-to-1 transition. Each new state keeps the cheaper of its two candidate predecessors, and its survivor bit holds the number of that predecessor state (1 means state 1).
- R4: If the two candidates for a state cost the same, the survivor bit is 0. If the two updated path metrics are equal, traceback starts in state 0.
- R5: After every update, both metrics have had the smaller one subtracted, so at least one stored metric is 0 and neither exceeds 1. This holds for any sample values, including long runs of extreme ones.
- R6: Traceback starts at the state with the smaller updated metric. It follows the current survivor pair and then the `TB_LEN-2` stored stages, newest first. The state it reaches is the decoded bit for the sample accepted `TB_LEN-1` samples earlier, presented with the valid pulse of R2.
- R7: A cycle with `smp_valid` low changes neither metric nor any survivor bit. `dec_valid` is low in the following cycle and `dec_bit` keeps its value, and decoding continues across such gaps as if they were absent.
- R8: After reset, feed noiseless samples (x[n] + x[n-1], with x[-1] = 0) whose first data bit is 0. The decoded stream then equals the data stream exactly.
- R9: `smp_data` is a two's complement value. A negative sample s costs |s| + e, so it pulls the metrics toward the 0-to-0 transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_data | input | SW | Signed quantized received sample |
| dec_valid | output | 1 | `dec_bit` carries a new decoded bit this cycle |
| dec_bit | output | 1 | Decoded data bit |

## Verification
Two stimulus patterns give ties. A run of samples equal to 1 leaves the path metrics tied and makes every traceback pass through alternating states. A decoder that resolves either tie toward state 1 turns the expected all-ones output into zeros. Noisy and negative samples are compared against a bench model that scores costs as absolute distances. A decoder that treats the sample as unsigned, or uses the wrong expected level, drifts away from that model. A long run of alternating extreme samples checks renormalisation: a metric that is not pulled down wraps and corrupts later decisions. Idle gaps inside a noiseless stream must not shift the traceback window. A reset during the stream must restart the fill count, so that an early valid pulse, or one missing after the window fills, is caught.

// File: rtl/isi_viterbi2.sv
module isi_viterbi2 #(
  parameter int SW     = 6,
  parameter int TB_LEN = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_data,
  output logic                 dec_valid,
  output logic                 dec_bit
);
  // TB_LEN must be at least 3 so that one stored stage exists.
  localparam int MW    = SW + 2;
  localparam int DEPTH = TB_LEN - 2;
  localparam int CW    = $clog2(TB_LEN + 1);
  localparam logic [CW-1:0] FILL = CW'(TB_LEN - 1);

  function automatic logic [MW-1:0] cost(input logic signed [SW-1:0] s, input logic [1:0] e);
    logic signed [MW-1:0] d;
    d = MW'(s) - signed'(MW'(e));
    return d[MW-1] ? MW'(-d) : MW'(d);
  endfunction

  logic [MW-1:0]    pm0, pm1;
  logic [DEPTH-1:0] tr0, tr1;
  logic [CW-1:0]    fill;

  logic [MW-1:0] c00, c01, c10, c11, n0, n1, nmin;
  logic          sv0, sv1, start;

  assign c00   = pm0 + cost(smp_data, 2'd0);
  assign c01   = pm1 + cost(smp_data, 2'd1);
  assign c10   = pm0 + cost(smp_data, 2'd1);
  assign c11   = pm1 + cost(smp_data, 2'd2);
  assign sv0   = c01 < c00;
  assign sv1   = c11 < c10;
  assign n0    = sv0 ? c01 : c00;
  assign n1    = sv1 ? c11 : c10;
  assign start = n1 < n0;
  assign nmin  = start ? n1 : n0;

  logic traced;
  always_comb begin
    traced = start;
    traced = traced ? sv1 : sv0;
    for (int k = 0; k < DEPTH; k++)
      traced = traced ? tr1[k] : tr0[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm0       <= '0;
      pm1       <= '0;
      tr0       <= '0;
      tr1       <= '0;
      fill      <= '0;
      dec_valid <= 1'b0;
      dec_bit   <= 1'b0;
    end else begin
      dec_valid <= smp_valid && (fill == FILL);
      if (smp_valid) begin
        pm0     <= n0 - nmin;
        pm1     <= n1 - nmin;
        tr0     <= DEPTH'({tr0, sv0});
        tr1     <= DEPTH'({tr1, sv1});
        dec_bit <= traced;
        if (fill != FILL) fill <= fill + 1'b1;
      end
    end
  end

  p_floor_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm0 == '0) || (pm1 == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm0 <= MW'(1)) && (pm1 <= MW'(1)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(pm0) && $stable(pm1) && $stable(tr0) && $stable(tr1)
                   && !dec_valid && $stable(dec_bit));

  p_valid_follows_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(smp_valid));

  p_valid_after_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (fill == FILL));
endmodule

// File: tb/isi_viterbi2_test.sv
`timescale 1ns/1ps
module isi_viterbi2_test;
  localparam int SW = 6;
  localparam int L  = 6;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_valid = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic                 dec_valid, dec_bit;

  isi_viterbi2 #(.SW(SW), .TB_LEN(L)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  always #4 clk = ~clk;

  typedef struct { bit v; string req; } exp_t;
  exp_t expq[$];
  int   compared = 0, mismatched = 0;
  int   rpm0 = 0, rpm1 = 0, nacc = 0;
  bit   h0[$], h1[$], truth[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int iabs(input int a);
    return (a < 0) ? -a : a;
  endfunction

  function automatic void model_clear();
    rpm0 = 0; rpm1 = 0; nacc = 0;
    h0.delete(); h1.delete(); truth.delete(); expq.delete();
  endfunction

  task automatic send(input int s, input bit use_truth, input bit x, input string req);
    int c00, c01, c10, c11, n0, n1, mn;
    bit s0, s1, cur;
    exp_t e;
    c00 = rpm0 + iabs(s);     c01 = rpm1 + iabs(s - 1);
    c10 = rpm0 + iabs(s - 1); c11 = rpm1 + iabs(s - 2);
    s0 = c01 < c00; s1 = c11 < c10;
    n0 = s0 ? c01 : c00; n1 = s1 ? c11 : c10;
    cur = n1 < n0;
    mn = cur ? n1 : n0;
    rpm0 = n0 - mn; rpm1 = n1 - mn;
    h0.push_front(s0); h1.push_front(s1); truth.push_front(x);
    nacc++;
    if (nacc >= L) begin
      for (int k = 0; k < L - 1; k++) cur = cur ? h1[k] : h0[k];
      e.v = use_truth ? truth[L-1] : cur;
      e.req = req;
      expq.push_back(e);
    end
    while (h0.size() > L) begin
      void'(h0.pop_back()); void'(h1.pop_back()); void'(truth.pop_back());
    end
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = SW'(s);
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = SW'($urandom);
  endtask

  task automatic do_reset();
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    check(!dec_valid && !dec_bit, "R1", {dec_valid, dec_bit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dec_valid && !dec_bit, "R1", {dec_valid, dec_bit}, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (expq.size() == 0) check(1'b0, "R2", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        check(dec_bit == e.v, e.req, dec_bit, e.v);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic clean_run(input int n, input bit gaps, input string req);
    bit prev, x;
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      x = (i == 0) ? 1'b0 : 1'($urandom);
      send(int'(x) + int'(prev), 1'b1, x, req);
      prev = x;
      if (gaps && (i % 3 == 1)) begin
        idle();
        @(posedge clk); #1;
        check(!dec_valid, "R7", dec_valid, 0);
      end
    end
  endtask

  initial begin
    bit prev, x;
    int s;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!dec_valid && !dec_bit, "R1", {dec_valid, dec_bit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!dec_valid, "R1", dec_valid, 0);

    // R2 / R6: no valid during fill, first valid with the L-th sample
    prev = 1'b0;
    for (int i = 0; i < L; i++) begin
      x = (i == 0) ? 1'b0 : 1'($urandom);
      send(int'(x) + int'(prev), 1'b1, x, "R6");
      prev = x;
      @(posedge clk); #1;
      if (i < L - 1) check(!dec_valid, "R2", dec_valid, 0);
      else           check(dec_valid, "R6", dec_valid, 1);
    end
    idle();

    // R8: noiseless stream decodes exactly
    do_reset();
    clean_run(60, 1'b0, "R8");

    // R7: idle gaps inside a noiseless stream
    do_reset();
    clean_run(40, 1'b1, "R7");

    // R4: all-ones samples tie metrics every cycle; traceback yields 1
    do_reset();
    for (int i = 0; i < 16; i++) send(1, 1'b1, 1'b1, "R4");
    idle();

    // R3 / R9: noisy and negative samples against the cost model
    do_reset();
    prev = 1'b0;
    for (int i = 0; i < 200; i++) begin
      x = 1'($urandom);
      s = int'(x) + int'(prev) + (int'($urandom % 7) - 3);
      if (i % 11 == 5) s = -int'($urandom % 30) - 1;
      send(s, 1'b0, x, (s < 0) ? "R9" : "R3");
      prev = x;
    end
    idle();

    // R5: long run of extreme samples, then ordinary ones
    for (int i = 0; i < 400; i++)
      send((i % 2 == 0) ? -(1 <<< (SW - 1)) : (1 <<< (SW - 1)) - 1, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 40; i++) send(int'($urandom % 3), 1'b0, 1'b0, "R5");
    idle();

    // R2: reset in mid-stream restarts the fill count
    do_reset();
    for (int i = 0; i < L; i++) begin
      send(int'($urandom % 3), 1'b0, 1'b0, "R2");
      @(posedge clk); #1;
      check(dec_valid == (i == L - 1), "R2", dec_valid, (i == L - 1));
    end
    idle();
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule